// File: doc/BRIEF.md
# Cascaded Position-Speed-Torque Mode Selector

This block is the outer loop of a servo drive. Once per sample strobe it turns a rotor position request into a quadrature current setpoint. It estimates shaft speed by differencing the present rotor position against the one captured at the last strobe. A position regulator turns the position error into an internal speed request. The speed error then passes through a second regulator, which gives an internal torque request.

Two enable inputs let an outside controller take over a stage. With the speed enable set, an external speed command replaces the position regulator's output. With the torque enable set, an external torque command replaces the speed regulator's output. A regulator whose output is not in use holds its integrator, so it does not wind up while bypassed.

The chosen speed and torque commands appear on monitor outputs. The chosen torque command also drives the quadrature setpoint. The direct-axis setpoint is held at zero.

Top module: `servo_cascade_sel`

## Requirements
- R1: A synchronous active-high reset clears every output, both integrators and the stored previous position to zero.
- R2: All outputs are registered. They change only on the clock edge at which `sample_stb` is high, and they hold their values on every other edge.
- R3: The speed estimate is `rotor_pos` minus the position stored at the previous strobe, taken modulo 2^W and read as a W-bit two's-complement number. A wrap from 65530 to 5 gives +11. The stored position is zero after reset.
- R4: The position error is `pos_req` minus `rotor_pos`, taken modulo 2^W and read as signed. With `spd_en` low, the position regulator's output is the speed command and appears on `spd_cmd_mon`.
- R5: With `spd_en` high, `ext_spd` is the speed command and appears on `spd_cmd_mon` after the strobe edge.
- R6: The speed error is the selected speed command minus the speed estimate, clamped to ±(2^(W-1)-1). It feeds the speed regulator, whose output is the internal torque command.
- R7: With `trq_en` high, `ext_trq` is the torque command. Otherwise the speed regulator's output is the torque command. The chosen value appears on both `trq_cmd_mon` and `iq_set`.
- R8: `id_set` is zero at all times.
- R9: Each regulator computes its output as clamp(((KP·e) >>> FRAC) + I, ±LIM), using the integrator value I from before the strobe. On a strobe the integrator becomes clamp(I + ((KI·e) >>> FRAC), ±LIM). The shift `>>>` is arithmetic, rounding toward minus infinity.
- R10: The position regulator's integrator is frozen on strobes where `spd_en` is high. The speed regulator's integrator is frozen on strobes where `trq_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_stb | input | 1 | Advances the cascade by one sample |
| pos_req | input | W | Requested rotor position, unsigned, one turn per 2^W |
| rotor_pos | input | W | Measured rotor position, unsigned |
| spd_en | input | 1 | Selects the external speed command |
| ext_spd | input | W | External speed command, signed |
| trq_en | input | 1 | Selects the external torque command |
| ext_trq | input | W | External torque command, signed |
| spd_cmd_mon | output | W | Selected speed command, signed |
| trq_cmd_mon | output | W | Selected torque command, signed |
| iq_set | output | W | Quadrature current setpoint, signed |
| id_set | output | W | Direct current setpoint, zero |

## Verification
The assertions assume that `sample_stb` is a clean level that is sampled at the clock edge. They also assume that reset is held for at least one edge before any strobe, so that the previous-position register and the integrators start from zero. The stimulus changes inputs only at the falling clock edge. It raises the strobe for single cycles separated by idle cycles in which the data inputs are altered, so the hold behaviour is exposed. It sweeps all four combinations of the enables, with small and large rotor steps and position requests that cross the wrap point.

// File: rtl/servo_casc_pkg.sv
package servo_casc_pkg;
  localparam int ACC_W = 48;

  function automatic logic signed [ACC_W-1:0] clamp_acc(
    input logic signed [ACC_W-1:0] v,
    input logic signed [ACC_W-1:0] lim
  );
    if (v > lim) return lim;
    if (v < -lim) return -lim;
    return v;
  endfunction
endpackage

// File: rtl/servo_speed_est.sv
module servo_speed_est #(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                strobe,
  input  logic [W-1:0]        pos_now,
  output logic signed [W-1:0] est
);
  logic [W-1:0] prev_q;
  logic [W-1:0] delta;

  always_comb begin
    delta = pos_now - prev_q;
    est   = $signed(delta);
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else if (strobe) prev_q <= pos_now;
  end

  // R3
  prev_capture_chk: assert property (@(posedge clk) disable iff (rst)
    strobe |=> (prev_q == $past(pos_now)));

  // R3
  prev_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> $stable(prev_q));
endmodule

// File: rtl/servo_pi_stage.sv
module servo_pi_stage import servo_casc_pkg::*; #(
  parameter int W    = 16,
  parameter int KP   = 64,
  parameter int KI   = 8,
  parameter int FRAC = 6,
  parameter int LIM  = 12000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                strobe,
  input  logic                hold,
  input  logic signed [W-1:0] err,
  output logic signed [W-1:0] u
);
  localparam logic signed [ACC_W-1:0] KP_X  = ACC_W'(KP);
  localparam logic signed [ACC_W-1:0] KI_X  = ACC_W'(KI);
  localparam logic signed [ACC_W-1:0] LIM_X = ACC_W'(LIM);

  logic signed [W-1:0]     integ_q;
  logic signed [ACC_W-1:0] err_x;
  logic signed [ACC_W-1:0] p_term;
  logic signed [ACC_W-1:0] i_term;
  logic signed [ACC_W-1:0] sum_u;
  logic signed [ACC_W-1:0] sum_i;
  logic signed [ACC_W-1:0] u_acc;
  logic signed [ACC_W-1:0] i_acc;

  always_comb begin
    err_x  = ACC_W'(err);
    p_term = (err_x * KP_X) >>> FRAC;
    i_term = (err_x * KI_X) >>> FRAC;
    sum_u  = p_term + ACC_W'(integ_q);
    sum_i  = i_term + ACC_W'(integ_q);
    u_acc  = clamp_acc(sum_u, LIM_X);
    i_acc  = clamp_acc(sum_i, LIM_X);
    u      = W'(u_acc);
  end

  always_ff @(posedge clk) begin
    if (rst) integ_q <= '0;
    else if (strobe && !hold) integ_q <= W'(i_acc);
  end

  // R9
  integ_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    (integ_q <= W'(LIM)) && (integ_q >= -W'(LIM)));

  // R9
  out_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    (u <= W'(LIM)) && (u >= -W'(LIM)));

  // R10
  frozen_integ_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe && hold) |=> $stable(integ_q));
endmodule

// File: rtl/servo_cmd_reg.sv
module servo_cmd_reg #(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                strobe,
  input  logic                use_ext,
  input  logic signed [W-1:0] ext_cmd,
  input  logic signed [W-1:0] int_cmd,
  output logic signed [W-1:0] cmd_q
);
  always_ff @(posedge clk) begin
    if (rst) cmd_q <= '0;
    else if (strobe) cmd_q <= use_ext ? ext_cmd : int_cmd;
  end
endmodule

// File: rtl/servo_cascade_sel.sv
module servo_cascade_sel import servo_casc_pkg::*; #(
  parameter int W        = 16,
  parameter int POS_KP   = 64,
  parameter int POS_KI   = 8,
  parameter int SPD_KP   = 96,
  parameter int SPD_KI   = 16,
  parameter int FRAC     = 6,
  parameter int SPD_LIM  = 12000,
  parameter int TRQ_LIM  = 9000
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sample_stb,
  input  logic [W-1:0] pos_req,
  input  logic [W-1:0] rotor_pos,
  input  logic         spd_en,
  input  logic [W-1:0] ext_spd,
  input  logic         trq_en,
  input  logic [W-1:0] ext_trq,
  output logic [W-1:0] spd_cmd_mon,
  output logic [W-1:0] trq_cmd_mon,
  output logic [W-1:0] iq_set,
  output logic [W-1:0] id_set
);
  localparam logic signed [ACC_W-1:0] ERR_MAX = ACC_W'((64'sd1 <<< (W - 1)) - 1);

  logic signed [W-1:0]     spd_est;
  logic signed [W-1:0]     pos_err;
  logic signed [W-1:0]     spd_int;
  logic signed [W-1:0]     spd_sel;
  logic signed [ACC_W-1:0] spd_diff;
  logic signed [ACC_W-1:0] spd_diff_c;
  logic signed [W-1:0]     spd_err;
  logic signed [W-1:0]     trq_int;
  logic signed [W-1:0]     spd_q;
  logic signed [W-1:0]     trq_q;
  logic [W-1:0]            pos_delta;

  servo_speed_est #(.W(W)) est_i (
    .clk(clk), .rst(rst), .strobe(sample_stb),
    .pos_now(rotor_pos), .est(spd_est)
  );

  always_comb begin
    pos_delta  = pos_req - rotor_pos;
    pos_err    = $signed(pos_delta);
    spd_sel    = spd_en ? $signed(ext_spd) : spd_int;
    spd_diff   = ACC_W'(spd_sel) - ACC_W'(spd_est);
    spd_diff_c = clamp_acc(spd_diff, ERR_MAX);
    spd_err    = W'(spd_diff_c);
  end

  servo_pi_stage #(.W(W), .KP(POS_KP), .KI(POS_KI), .FRAC(FRAC), .LIM(SPD_LIM)) pos_pi_i (
    .clk(clk), .rst(rst), .strobe(sample_stb), .hold(spd_en),
    .err(pos_err), .u(spd_int)
  );

  servo_pi_stage #(.W(W), .KP(SPD_KP), .KI(SPD_KI), .FRAC(FRAC), .LIM(TRQ_LIM)) spd_pi_i (
    .clk(clk), .rst(rst), .strobe(sample_stb), .hold(trq_en),
    .err(spd_err), .u(trq_int)
  );

  servo_cmd_reg #(.W(W)) spd_reg_i (
    .clk(clk), .rst(rst), .strobe(sample_stb), .use_ext(spd_en),
    .ext_cmd($signed(ext_spd)), .int_cmd(spd_int), .cmd_q(spd_q)
  );

  servo_cmd_reg #(.W(W)) trq_reg_i (
    .clk(clk), .rst(rst), .strobe(sample_stb), .use_ext(trq_en),
    .ext_cmd($signed(ext_trq)), .int_cmd(trq_int), .cmd_q(trq_q)
  );

  assign spd_cmd_mon = spd_q;
  assign trq_cmd_mon = trq_q;
  assign iq_set      = trq_q;
  assign id_set      = '0;

  // R5
  spd_override_chk: assert property (@(posedge clk) disable iff (rst)
    (sample_stb && spd_en) |=> (spd_cmd_mon == $past(ext_spd)));

  // R7
  trq_override_chk: assert property (@(posedge clk) disable iff (rst)
    (sample_stb && trq_en) |=> (iq_set == $past(ext_trq)));

  // R2
  outputs_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !sample_stb |=> ($stable(iq_set) && $stable(spd_cmd_mon) && $stable(trq_cmd_mon)));
endmodule

// File: tb/servo_cascade_sel_tb.sv
module servo_cascade_sel_tb_top;
  localparam int CLK_P   = 10;
  localparam int W       = 16;
  localparam int POS_KP  = 64;
  localparam int POS_KI  = 8;
  localparam int SPD_KP  = 96;
  localparam int SPD_KI  = 16;
  localparam int FRAC    = 6;
  localparam int SPD_LIM = 12000;
  localparam int TRQ_LIM = 9000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sample_stb = 1'b0;
  logic [W-1:0] pos_req = '0, rotor_pos = '0, ext_spd = '0, ext_trq = '0;
  logic spd_en = 1'b0, trq_en = 1'b0;
  logic [W-1:0] spd_cmd_mon, trq_cmd_mon, iq_set, id_set;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  int m_prev = 0, m_ip = 0, m_is = 0, m_spd = 0, m_trq = 0;
  int unsigned seed = 32'h1234_5678;

  always #(CLK_P/2) clk = ~clk;

  servo_cascade_sel #(
    .W(W), .POS_KP(POS_KP), .POS_KI(POS_KI), .SPD_KP(SPD_KP), .SPD_KI(SPD_KI),
    .FRAC(FRAC), .SPD_LIM(SPD_LIM), .TRQ_LIM(TRQ_LIM)
  ) dut_i (
    .clk(clk), .rst(rst), .sample_stb(sample_stb), .pos_req(pos_req),
    .rotor_pos(rotor_pos), .spd_en(spd_en), .ext_spd(ext_spd), .trq_en(trq_en),
    .ext_trq(ext_trq), .spd_cmd_mon(spd_cmd_mon), .trq_cmd_mon(trq_cmd_mon),
    .iq_set(iq_set), .id_set(id_set)
  );

  function automatic int clampi(int v, int l);
    if (v > l) return l;
    if (v < -l) return -l;
    return v;
  endfunction

  function automatic int sx(logic [W-1:0] v);
    return int'($signed(v));
  endfunction

  function automatic int unsigned rnd();
    seed ^= seed << 13;
    seed ^= seed >> 17;
    seed ^= seed << 5;
    return seed;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Independent model of one strobe (R3, R4, R6, R9, R10)
  task automatic model_step();
    logic [W-1:0] d;
    int est, perr, p, spd_int, ssel, serr, trq_int;
    d = rotor_pos - W'(m_prev);
    est = sx(d);
    d = pos_req - rotor_pos;
    perr = sx(d);
    p = (perr * POS_KP) >>> FRAC;
    spd_int = clampi(p + m_ip, SPD_LIM);
    if (!spd_en) m_ip = clampi(m_ip + ((perr * POS_KI) >>> FRAC), SPD_LIM);
    ssel = spd_en ? sx(ext_spd) : spd_int;
    serr = clampi(ssel - est, 32767);
    p = (serr * SPD_KP) >>> FRAC;
    trq_int = clampi(p + m_is, TRQ_LIM);
    if (!trq_en) m_is = clampi(m_is + ((serr * SPD_KI) >>> FRAC), TRQ_LIM);
    m_spd = ssel;
    m_trq = trq_en ? sx(ext_trq) : trq_int;
    m_prev = int'(rotor_pos);
  endtask

  task automatic check_outs(string phase);
    chk({"R4/R5 spd_cmd_mon ", phase}, sx(spd_cmd_mon), m_spd);
    chk({"R6/R7 trq_cmd_mon ", phase}, sx(trq_cmd_mon), m_trq);
    chk({"R7 iq_set ", phase}, sx(iq_set), m_trq);
    chk({"R8 id_set ", phase}, sx(id_set), 0);
  endtask

  // Inputs set at the falling edge, one strobe edge, check at the next falling edge
  task automatic do_strobe(logic [W-1:0] preq, logic [W-1:0] rot, bit se,
                           logic [W-1:0] es, bit te, logic [W-1:0] et, int idle);
    pos_req = preq; rotor_pos = rot; spd_en = se; ext_spd = es;
    trq_en = te; ext_trq = et; sample_stb = 1'b1;
    model_step();
    @(negedge clk);
    sample_stb = 1'b0;
    check_outs("strobe");
    for (int k = 0; k < idle; k++) begin
      pos_req = W'(rnd()); rotor_pos = W'(rnd()); ext_spd = W'(rnd());
      ext_trq = W'(rnd()); spd_en = rnd() % 2 == 0; trq_en = rnd() % 2 == 0;
      @(negedge clk);
      // R2: no strobe, outputs hold
      check_outs("R2 idle");
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] rot;
    rot = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 spd_cmd_mon", sx(spd_cmd_mon), 0);
    chk("R1 trq_cmd_mon", sx(trq_cmd_mon), 0);
    chk("R1 iq_set", sx(iq_set), 0);
    chk("R1 id_set", sx(id_set), 0);
    rst = 1'b0;
    @(negedge clk);

    // R3: wrap of the position difference, 65530 -> 5 gives +11
    do_strobe(16'd65530, 16'd65530, 1'b1, 16'd0, 1'b0, 16'd0, 0);
    do_strobe(16'd5, 16'd5, 1'b1, 16'd0, 1'b0, 16'd0, 1);
    // R4: position request across the wrap point
    do_strobe(16'd3, 16'd65533, 1'b0, 16'd0, 1'b0, 16'd0, 1);

    // Sweep all enable combinations (R4, R5, R6, R7, R9, R10)
    for (int mode = 0; mode < 4; mode++) begin
      for (int s = 0; s < 400; s++) begin
        logic [W-1:0] preq, es, et;
        int step;
        step = (s % 50 == 0) ? int'(rnd() % 65536) : int'(rnd() % 801) - 400;
        rot = rot + W'(step);
        preq = (s % 7 == 0) ? W'(rnd()) : rot + W'(int'(rnd() % 2001) - 1000);
        es = W'(int'(rnd() % 20001) - 10000);
        et = W'(rnd());
        do_strobe(preq, rot, mode[0], es, mode[1], et, int'(rnd() % 3));
      end
    end

    // R10: long bypass then release, integrators must resume from frozen values
    for (int s = 0; s < 60; s++)
      do_strobe(16'd30000, rot, 1'b1, 16'd12345, 1'b1, 16'd777, 0);
    for (int s = 0; s < 60; s++)
      do_strobe(16'd30000, rot, 1'b0, 16'd0, 1'b0, 16'd0, 0);

    // R1: reset in mid-run clears state again
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    m_prev = 0; m_ip = 0; m_is = 0; m_spd = 0; m_trq = 0;
    check_outs("R1 re-reset");
    do_strobe(16'd100, 16'd40, 1'b0, 16'd0, 1'b0, 16'd0, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule